// File: doc/BRIEF.md
# Stereo/Mono Channel Converter

This block sits in an audio stream between the stream interface and the serial port. It carries signed samples one per beat, each beat tagged with a channel index and an end-of-frame marker, on valid/ready handshakes. Each beat can leave unchanged, or the stream can be narrowed from two channels to one, or widened from one channel to two. Two independent lanes are built side by side. Lane 0 carries playback and lane 1 carries capture. Each lane has its own conversion setting, mix choice, fill choice and sample width.

Narrowing takes two input beats, channel 0 first, and emits one. It can keep the first beat, keep the second, or output their average rounded toward negative infinity. Widening takes one input beat and emits two, channel 0 first. The second beat is either zero or a copy of the sample. The sample width can be 8, 16 or 32 bits. Converted samples are read from the low bits of the data bus and sign-extended to the full bus.

A configuration change only takes effect when the lane is between frames, so a channel pair is never split across two settings.

Top module: `chconv_top`

## Requirements
- R1: After reset every output valid is low, and every input ready is high while the lane is set to pass-through.
- R2: With operation code 0 or 3 (pass-through), each input beat appears once at the output with data, channel index and end-of-frame unchanged, and the lane can accept one beat per cycle.
- R3: With operation code 1 (narrow) and mix code 0, each pair of input beats yields one output beat. That beat holds the first beat of the pair sign-extended, with channel index 0, and its end-of-frame is taken from the second beat. The first beat of a pair produces no output.
- R4: With operation code 1 and mix code 1, the output beat holds the second beat of the pair.
- R5: With operation code 1 and mix code 2 or 3, the output is the sum of both sign-extended samples shifted right arithmetically by one bit. This rounds toward negative infinity and never overflows.
- R6: With operation code 2 (widen) and fill code 0, each input beat yields two output beats. The first is the sample on channel 0 and the second is zero on channel 1. End-of-frame appears only on the channel-1 beat, and only when the input beat carried it.
- R7: With operation code 2 and fill code 1, both output beats carry the sign-extended sample.
- R8: Width code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. Converted samples use only that many low bits of the input and are sign-extended. Pass-through data is never altered.
- R9: Configuration presented while a frame is in progress is ignored until the lane has emitted that frame's end-of-frame beat. The next frame then uses the configuration present when its first beat is accepted.
- R10: Lane 0 (playback) and lane 1 (capture) have separate settings and separate streams. Traffic and settings on one lane never change the other lane's output.
- R11: While an output beat is valid and not accepted, it stays valid and its data, channel index and end-of-frame stay unchanged.
- R12: When widening, input ready is low in the cycle after a beat is accepted, while the channel-1 beat is being produced. A continuous widening stream is therefore accepted every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_op | input | 2x2 | Per-lane operation: 0/3 pass, 1 narrow, 2 widen |
| cfg_mix | input | 2x2 | Per-lane narrowing choice: 0 first, 1 second, 2/3 average |
| cfg_dup | input | 2 | Per-lane widening fill: 0 zero, 1 copy |
| cfg_wsel | input | 2x2 | Per-lane sample width: 0 8 bits, 1 16 bits, 2/3 32 bits |
| in_valid | input | 2 | Input beat valid per lane |
| in_ready | output | 2 | Input beat ready per lane |
| in_data | input | 2x32 | Input sample per lane |
| in_ch | input | 2x4 | Input channel index per lane |
| in_eof | input | 2 | Input end-of-frame per lane |
| out_valid | output | 2 | Output beat valid per lane |
| out_ready | input | 2 | Output beat ready per lane |
| out_data | output | 2x32 | Output sample per lane |
| out_ch | output | 2x4 | Output channel index per lane |
| out_eof | output | 2 | Output end-of-frame per lane |

## Verification
Narrowing is tested with pairs in which the two samples differ in sign and size. This shows which beat each mix code keeps. The average is checked on odd negative sums, to confirm rounding toward negative infinity, and on two maximum positive values, to catch overflow. Widening is checked with both fill codes and with end-of-frame on the middle and last input beats, which shows where end-of-frame is placed. Narrow-width inputs with junk in the upper bits show whether the sign comes from the right bit. A setting changed in the middle of a frame, random output stalls, and traffic on only one lane at a time test the frame-boundary, hold-stable and independence rules.

// File: rtl/chconv_pkg.sv
`timescale 1ns/100ps
package chconv_pkg;

    localparam int unsigned NPATH = 2;

    typedef enum logic [1:0] {
        OP_PASS     = 2'd0,
        OP_NARROW   = 2'd1,
        OP_WIDEN    = 2'd2,
        OP_PASS_ALT = 2'd3
    } conv_op_e;

    typedef enum logic [1:0] {
        LS_FIRST  = 2'd0,
        LS_SECOND = 2'd1,
        LS_DUP    = 2'd2
    } lane_state_e;

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] mix;
        logic       dup;
        logic [1:0] wsel;
    } lane_cfg_t;

endpackage

// File: rtl/chconv_sample_math.sv
`timescale 1ns/100ps
module chconv_sample_math #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_raw,
    input  logic [DATA_W-1:0] b_raw,
    input  logic [1:0]        wsel,
    input  logic [1:0]        mix,
    output logic [DATA_W-1:0] b_ext,
    output logic [DATA_W-1:0] mono
);

    localparam int unsigned W_NARROW = 8;
    localparam int unsigned W_MID    = 16;

    function automatic logic [DATA_W-1:0] sext(input logic [DATA_W-1:0] v,
                                               input logic [1:0] w);
        logic [DATA_W-1:0] r;
        case (w)
            2'd0:    r = {{(DATA_W-W_NARROW){v[W_NARROW-1]}}, v[W_NARROW-1:0]};
            2'd1:    r = {{(DATA_W-W_MID){v[W_MID-1]}}, v[W_MID-1:0]};
            default: r = v;
        endcase
        return r;
    endfunction

    logic [DATA_W-1:0] a_ext;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] avg;

    assign a_ext = sext(a_raw, wsel);
    assign b_ext = sext(b_raw, wsel);
    // one guard bit keeps the sum exact; dropping bit 0 floors the half
    assign sum   = {a_ext[DATA_W-1], a_ext} + {b_ext[DATA_W-1], b_ext};
    assign avg   = DATA_W'(sum >> 1);

    always_comb begin
        case (mix)
            2'd0:    mono = a_ext;
            2'd1:    mono = b_ext;
            default: mono = avg;
        endcase
    end

endmodule

// File: rtl/chconv_lane.sv
`timescale 1ns/100ps
module chconv_lane
    import chconv_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lane_cfg_t         cfg_live,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CH_W-1:0]   in_ch,
    input  logic              in_eof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [CH_W-1:0]   out_ch,
    output logic              out_eof
);

    localparam logic [CH_W-1:0] CH_LEFT  = CH_W'(0);
    localparam logic [CH_W-1:0] CH_RIGHT = CH_W'(1);

    typedef struct packed {
        lane_state_e       state;
        logic              at_bound;
        lane_cfg_t         cfg;
        logic [DATA_W-1:0] hold;
        logic              hold_eof;
        logic              ov;
        logic [DATA_W-1:0] od;
        logic [CH_W-1:0]   oc;
        logic              oe;
    } lane_reg_t;

    lane_reg_t         lane_d, lane_q;
    lane_cfg_t         cfg_use;
    logic              slot_free;
    logic              rdy;
    logic              acc;
    logic              ld;
    logic [DATA_W-1:0] ld_data;
    logic [CH_W-1:0]   ld_ch;
    logic              ld_eof;
    logic [DATA_W-1:0] b_ext;
    logic [DATA_W-1:0] mono;

    assign cfg_use = lane_q.at_bound ? cfg_live : lane_q.cfg;

    chconv_sample_math #(.DATA_W(DATA_W)) u_math (
        .a_raw (lane_q.hold),
        .b_raw (in_data),
        .wsel  (cfg_use.wsel),
        .mix   (cfg_use.mix),
        .b_ext (b_ext),
        .mono  (mono)
    );

    always_comb begin
        lane_d    = lane_q;
        slot_free = !lane_q.ov || out_ready;
        ld        = 1'b0;
        ld_data   = '0;
        ld_ch     = CH_LEFT;
        ld_eof    = 1'b0;

        if (lane_q.ov && out_ready) begin
            lane_d.ov = 1'b0;
        end
        if (lane_q.at_bound) begin
            lane_d.cfg = cfg_live;
        end

        case (lane_q.state)
            LS_FIRST:  rdy = (cfg_use.op == OP_NARROW) ? 1'b1 : slot_free;
            LS_SECOND: rdy = slot_free;
            default:   rdy = 1'b0;
        endcase
        acc = in_valid && rdy;

        if (acc && lane_q.at_bound) begin
            lane_d.at_bound = 1'b0;
        end

        case (lane_q.state)
            LS_FIRST: begin
                if (acc) begin
                    case (cfg_use.op)
                        OP_NARROW: begin
                            lane_d.hold  = in_data;
                            lane_d.state = LS_SECOND;
                        end
                        OP_WIDEN: begin
                            ld              = 1'b1;
                            ld_data         = b_ext;
                            ld_ch           = CH_LEFT;
                            ld_eof          = 1'b0;
                            lane_d.hold     = cfg_use.dup ? b_ext : '0;
                            lane_d.hold_eof = in_eof;
                            lane_d.state    = LS_DUP;
                        end
                        default: begin
                            ld      = 1'b1;
                            ld_data = in_data;
                            ld_ch   = in_ch;
                            ld_eof  = in_eof;
                        end
                    endcase
                end
            end
            LS_SECOND: begin
                if (acc) begin
                    ld           = 1'b1;
                    ld_data      = mono;
                    ld_ch        = CH_LEFT;
                    ld_eof       = in_eof;
                    lane_d.state = LS_FIRST;
                end
            end
            default: begin
                if (slot_free) begin
                    ld           = 1'b1;
                    ld_data      = lane_q.hold;
                    ld_ch        = CH_RIGHT;
                    ld_eof       = lane_q.hold_eof;
                    lane_d.state = LS_FIRST;
                end
            end
        endcase

        if (ld) begin
            lane_d.ov = 1'b1;
            lane_d.od = ld_data;
            lane_d.oc = ld_ch;
            lane_d.oe = ld_eof;
            if (ld_eof) begin
                lane_d.at_bound = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q          <= '0;
            lane_q.state    <= LS_FIRST;
            lane_q.at_bound <= 1'b1;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign in_ready  = rdy;
    assign out_valid = lane_q.ov;
    assign out_data  = lane_q.od;
    assign out_ch    = lane_q.oc;
    assign out_eof   = lane_q.oe;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ch) && $stable(out_eof))); // R11

    AST_WIDEN_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && lane_q.state == LS_FIRST && cfg_use.op == OP_WIDEN) |=> !in_ready); // R12

    AST_PAIR_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && lane_q.state == LS_FIRST && cfg_use.op == OP_NARROW && !out_valid) |=> !out_valid); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!lane_q.at_bound) |=> $stable(lane_q.cfg)); // R9

endmodule

// File: rtl/chconv_top.sv
`timescale 1ns/100ps
module chconv_top
    import chconv_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CH_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPATH-1:0][1:0]        cfg_op,
    input  logic [NPATH-1:0][1:0]        cfg_mix,
    input  logic [NPATH-1:0]             cfg_dup,
    input  logic [NPATH-1:0][1:0]        cfg_wsel,
    input  logic [NPATH-1:0]             in_valid,
    output logic [NPATH-1:0]             in_ready,
    input  logic [NPATH-1:0][DATA_W-1:0] in_data,
    input  logic [NPATH-1:0][CH_W-1:0]   in_ch,
    input  logic [NPATH-1:0]             in_eof,
    output logic [NPATH-1:0]             out_valid,
    input  logic [NPATH-1:0]             out_ready,
    output logic [NPATH-1:0][DATA_W-1:0] out_data,
    output logic [NPATH-1:0][CH_W-1:0]   out_ch,
    output logic [NPATH-1:0]             out_eof
);

    for (genvar p = 0; p < NPATH; p++) begin : g_lane
        lane_cfg_t lane_cfg;

        assign lane_cfg = '{op: cfg_op[p], mix: cfg_mix[p], dup: cfg_dup[p], wsel: cfg_wsel[p]};

        chconv_lane #(.DATA_W(DATA_W), .CH_W(CH_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_live  (lane_cfg),
            .in_valid  (in_valid[p]),
            .in_ready  (in_ready[p]),
            .in_data   (in_data[p]),
            .in_ch     (in_ch[p]),
            .in_eof    (in_eof[p]),
            .out_valid (out_valid[p]),
            .out_ready (out_ready[p]),
            .out_data  (out_data[p]),
            .out_ch    (out_ch[p]),
            .out_eof   (out_eof[p])
        );
    end

endmodule

// File: tb/tb_chconv_top.sv
`timescale 1ns/100ps
module tb_chconv_top;

    localparam int DW = 32;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0][1:0]    cfg_op, cfg_mix, cfg_wsel;
    logic [1:0]         cfg_dup;
    logic [1:0]         in_valid, in_ready, in_eof, out_valid, out_ready, out_eof;
    logic [1:0][DW-1:0] in_data, out_data;
    logic [1:0][CW-1:0] in_ch, out_ch;

    chconv_top #(.DATA_W(DW), .CH_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_op(cfg_op), .cfg_mix(cfg_mix), .cfg_dup(cfg_dup), .cfg_wsel(cfg_wsel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_ch(in_ch), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ch(out_ch), .out_eof(out_eof)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [1:0] stall_en = 2'b00;
    logic [7:0] lfsr = 8'hA5;

    logic [DW-1:0] got_d [2][64];
    logic [CW-1:0] got_c [2][64];
    logic          got_e [2][64];
    int            got_n [2];
    int            acc_cyc [2][64];
    int            acc_n [2];
    int            hold_viol = 0;
    int            hold_evt = 0;
    logic [1:0]    chk_hold = 2'b00;
    logic [1:0][DW-1:0] prev_d;
    logic [1:0][CW-1:0] prev_c;
    logic [1:0]         prev_e;

    // Monitor: drives output ready at the falling edge, samples 1 ns later
    always begin
        @(negedge clk);
        cyc = cyc + 1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        for (int p = 0; p < 2; p++) out_ready[p] = stall_en[p] ? lfsr[p] : 1'b1;
        #1;
        for (int p = 0; p < 2; p++) begin
            if (rst_n) begin
                if (chk_hold[p]) begin
                    hold_evt++;
                    if (!out_valid[p] || out_data[p] != prev_d[p] || out_ch[p] != prev_c[p] || out_eof[p] != prev_e[p])
                        hold_viol++;
                end
                chk_hold[p] = out_valid[p] && !out_ready[p];
                prev_d[p] = out_data[p];
                prev_c[p] = out_ch[p];
                prev_e[p] = out_eof[p];
                if (out_valid[p] && out_ready[p] && got_n[p] < 64) begin
                    got_d[p][got_n[p]] = out_data[p];
                    got_c[p][got_n[p]] = out_ch[p];
                    got_e[p][got_n[p]] = out_eof[p];
                    got_n[p]++;
                end
                if (in_valid[p] && in_ready[p] && acc_n[p] < 64) begin
                    acc_cyc[p][acc_n[p]] = cyc;
                    acc_n[p]++;
                end
            end
        end
    end

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_beat(input int p, input int i, input logic [DW-1:0] d,
                            input logic [CW-1:0] c, input logic e, input string req);
        if (i >= got_n[p]) begin
            chk(req, "beat present", 64'(got_n[p]), 64'(i + 1));
        end else begin
            chk(req, $sformatf("lane%0d beat%0d data", p, i), 64'(got_d[p][i]), 64'(d));
            chk(req, $sformatf("lane%0d beat%0d ch", p, i), 64'(got_c[p][i]), 64'(c));
            chk(req, $sformatf("lane%0d beat%0d eof", p, i), 64'(got_e[p][i]), 64'(e));
        end
    endtask

    task automatic clear();
        got_n[0] = 0; got_n[1] = 0;
        acc_n[0] = 0; acc_n[1] = 0;
    endtask

    task automatic drain(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int p, input logic [1:0] op, input logic [1:0] mix,
                           input logic dup, input logic [1:0] wsel);
        cfg_op[p] = op; cfg_mix[p] = mix; cfg_dup[p] = dup; cfg_wsel[p] = wsel;
    endtask

    task automatic send(input int p, input logic [DW-1:0] d, input logic [CW-1:0] c, input logic e);
        in_valid[p] = 1'b1; in_data[p] = d; in_ch[p] = c; in_eof[p] = e;
        #0.5;
        while (!in_ready[p]) begin
            @(negedge clk);
            #0.5;
        end
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    task automatic t_reset();
        #0.5;
        chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk("R1", "in_ready after reset", 64'(in_ready), 64'd3);
        @(negedge clk);
    endtask

    task automatic t_pass();
        clear();
        set_cfg(0, 2'd0, 2'd0, 1'b0, 2'd0);
        send(0, 32'hDEADBEEF, 4'd5, 1'b0);
        send(0, 32'h00000080, 4'd6, 1'b0);
        send(0, 32'h12345678, 4'd7, 1'b1);
        drain(6);
        chk("R2", "pass beat count", 64'(got_n[0]), 64'd3);
        chk_beat(0, 0, 32'hDEADBEEF, 4'd5, 1'b0, "R2");
        chk_beat(0, 1, 32'h00000080, 4'd6, 1'b0, "R8 pass unaltered");
        chk_beat(0, 2, 32'h12345678, 4'd7, 1'b1, "R2");
        clear();
        set_cfg(0, 2'd3, 2'd0, 1'b0, 2'd1);
        send(0, 32'hCAFE8001, 4'd9, 1'b1);
        drain(6);
        chk("R2", "alt pass count", 64'(got_n[0]), 64'd1);
        chk_beat(0, 0, 32'hCAFE8001, 4'd9, 1'b1, "R2");
    endtask

    task automatic t_narrow(input logic [1:0] mix, input logic [1:0] wsel,
                            input logic [DW-1:0] a0, input logic [DW-1:0] b0,
                            input logic [DW-1:0] a1, input logic [DW-1:0] b1,
                            input logic [DW-1:0] e0, input logic [DW-1:0] e1, input string req);
        clear();
        set_cfg(0, 2'd1, mix, 1'b0, wsel);
        send(0, a0, 4'd0, 1'b0);
        send(0, b0, 4'd1, 1'b0);
        send(0, a1, 4'd0, 1'b0);
        send(0, b1, 4'd1, 1'b1);
        drain(6);
        chk(req, "narrow beat count", 64'(got_n[0]), 64'd2);
        chk_beat(0, 0, e0, 4'd0, 1'b0, req);
        chk_beat(0, 1, e1, 4'd0, 1'b1, req);
    endtask

    task automatic t_widen_zero();
        clear();
        set_cfg(0, 2'd2, 2'd0, 1'b0, 2'd2);
        send(0, 32'h00000011, 4'd0, 1'b0);
        send(0, 32'h00000022, 4'd0, 1'b1);
        drain(8);
        chk("R6", "widen zero count", 64'(got_n[0]), 64'd4);
        chk_beat(0, 0, 32'h00000011, 4'd0, 1'b0, "R6");
        chk_beat(0, 1, 32'h00000000, 4'd1, 1'b0, "R6");
        chk_beat(0, 2, 32'h00000022, 4'd0, 1'b0, "R6");
        chk_beat(0, 3, 32'h00000000, 4'd1, 1'b1, "R6");
    endtask

    task automatic t_widen_copy();
        clear();
        set_cfg(0, 2'd2, 2'd0, 1'b1, 2'd2);
        send(0, 32'hFFFFFFF9, 4'd0, 1'b1);
        drain(6);
        chk("R7", "widen copy count", 64'(got_n[0]), 64'd2);
        chk_beat(0, 0, 32'hFFFFFFF9, 4'd0, 1'b0, "R7");
        chk_beat(0, 1, 32'hFFFFFFF9, 4'd1, 1'b1, "R7");
        clear();
        set_cfg(0, 2'd2, 2'd0, 1'b1, 2'd0);
        send(0, 32'h000001FF, 4'd0, 1'b1);
        drain(6);
        chk_beat(0, 0, 32'hFFFFFFFF, 4'd0, 1'b0, "R8 widen 8-bit");
        chk_beat(0, 1, 32'hFFFFFFFF, 4'd1, 1'b1, "R8 widen 8-bit");
    endtask

    task automatic t_boundary();
        clear();
        set_cfg(0, 2'd1, 2'd0, 1'b0, 2'd2);
        send(0, 32'd10, 4'd0, 1'b0);
        set_cfg(0, 2'd2, 2'd1, 1'b1, 2'd0);
        send(0, 32'd20, 4'd1, 1'b0);
        send(0, 32'd30, 4'd0, 1'b0);
        send(0, 32'd40, 4'd1, 1'b1);
        drain(4);
        send(0, 32'h00000180, 4'd0, 1'b1);
        drain(6);
        chk("R9", "boundary beat count", 64'(got_n[0]), 64'd4);
        chk_beat(0, 0, 32'd10, 4'd0, 1'b0, "R9");
        chk_beat(0, 1, 32'd30, 4'd0, 1'b1, "R9");
        chk_beat(0, 2, 32'hFFFFFF80, 4'd0, 1'b0, "R9");
        chk_beat(0, 3, 32'hFFFFFF80, 4'd1, 1'b1, "R9");
    endtask

    task automatic t_indep();
        clear();
        set_cfg(0, 2'd1, 2'd0, 1'b0, 2'd2);
        set_cfg(1, 2'd2, 2'd0, 1'b1, 2'd2);
        send(1, 32'h00000055, 4'd3, 1'b1);
        drain(6);
        chk("R10", "lane0 silent", 64'(got_n[0]), 64'd0);
        chk("R10", "lane1 count", 64'(got_n[1]), 64'd2);
        chk_beat(1, 0, 32'h00000055, 4'd0, 1'b0, "R10");
        chk_beat(1, 1, 32'h00000055, 4'd1, 1'b1, "R10");
        send(0, 32'd8, 4'd0, 1'b0);
        send(0, 32'd9, 4'd1, 1'b1);
        drain(6);
        chk("R10", "lane1 unchanged", 64'(got_n[1]), 64'd2);
        chk_beat(0, 0, 32'd8, 4'd0, 1'b1, "R10");
    endtask

    task automatic t_backpressure();
        clear();
        hold_viol = 0; hold_evt = 0;
        stall_en = 2'b01;
        set_cfg(0, 2'd2, 2'd0, 1'b1, 2'd2);
        for (int i = 1; i <= 4; i++) send(0, DW'(i), 4'd0, i == 4);
        drain(40);
        stall_en = 2'b00;
        drain(2);
        chk("R11", "stalled widen count", 64'(got_n[0]), 64'd8);
        for (int i = 0; i < 8; i++)
            chk_beat(0, i, DW'(i / 2 + 1), CW'(i % 2), i == 7, "R11");
        chk("R11", "held beat changed", 64'(hold_viol), 64'd0);
        chk("R11", "stall seen", 64'(hold_evt > 0), 64'd1);
        clear();
        for (int i = 1; i <= 4; i++) send(0, DW'(i), 4'd0, i == 4);
        drain(6);
        chk("R12", "widen accept spacing", 64'(acc_cyc[0][3] - acc_cyc[0][0]), 64'd6);
        clear();
        set_cfg(0, 2'd0, 2'd0, 1'b0, 2'd2);
        for (int i = 1; i <= 4; i++) send(0, DW'(i), 4'd2, i == 4);
        drain(6);
        chk("R2", "pass accept spacing", 64'(acc_cyc[0][3] - acc_cyc[0][0]), 64'd3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        in_valid = '0; in_data = '0; in_ch = '0; in_eof = '0;
        cfg_op = '0; cfg_mix = '0; cfg_dup = '0; cfg_wsel = '0;
        out_ready = 2'b11;
        clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_narrow(2'd0, 2'd2, 32'd100, 32'hFFFFFFCE, 32'd7, 32'd9, 32'd100, 32'd7, "R3");
        t_narrow(2'd1, 2'd2, 32'd1, 32'd2, 32'hFFFFFFF0, 32'd11, 32'd2, 32'd11, "R4");
        t_narrow(2'd2, 2'd2, 32'hFFFFFFFD, 32'd0, 32'd100, 32'hFFFFFFCE, 32'hFFFFFFFE, 32'd25, "R5");
        t_narrow(2'd3, 2'd2, 32'd5, 32'd8, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'd6, 32'h7FFFFFFF, "R5");
        t_narrow(2'd0, 2'd0, 32'h12345680, 32'd0, 32'hAAAAAA7F, 32'd0, 32'hFFFFFF80, 32'h0000007F, "R8");
        t_narrow(2'd2, 2'd1, 32'h00008000, 32'h00007FFF, 32'hFFFF0002, 32'h00010004, 32'hFFFFFFFF, 32'd3, "R8");
        t_widen_zero();
        t_widen_copy();
        t_boundary();
        t_indep();
        t_backpressure();
        report();
        $finish;
    end

endmodule